// File: doc/BRIEF.md
# Page read scan register

This block is a test data register for a serial test port. It sends a whole memory page out on the serial output. The register holds only one 8-bit shift stage. While the controller stays in the shift state, the block reads the page one byte at a time from a page-buffer read port and moves each byte into that stage. The bits then leave the block least significant bit first. Nothing is loaded at capture time. A capture only rewinds the register to the start of the page.

The register becomes the active data register when the instruction register holds the code given by the `OPCODE` parameter (default 4'h7). A scan has two parts. The first 8 shift cycles carry zeros while the first byte is fetched. The page follows, so the apparent chain is `PAGE_BITS + 8` bits long (1032 by default). The serial input plays no part, and the block has no pin for it.

The read port has no back-pressure. The block pulses a read strobe with a byte address. The page buffer must then present that byte on the read data pins in the next clock cycle and hold it until the next strobe. There is no handshake or stall: the timing of the shift sequence alone sets the data rate.

Top module: `page_read_dr`

## Requirements
- R1: While `trst_n` is low, `tdo` and `rd_en` are 0.
- R2: After a capture with the register selected, the first 8 selected shift cycles drive `tdo` to 0.
- R3: Shift cycles 8+8n to 15+8n after a capture (n = 0 .. PAGE_BITS/8-1) drive bit 0 to bit 7 of page byte n on `tdo`, one bit per cycle, least significant bit first.
- R4: `rd_en` is high for exactly one cycle per page byte. That cycle is the selected shift cycle with index 6 modulo 8. `rd_addr` then equals the byte number n. The byte must appear on `rd_data` in the next cycle.
- R5: A selected capture sets the byte address back to 0 and clears the shift stage. It does so even in the middle of a page, and the next scan starts again from R2.
- R6: Once shift cycle `PAGE_BITS+8` is reached, no further strobe occurs and `tdo` stays 0 until the next capture.
- R7: A cycle with `shift_dr` low leaves the scan position unchanged. Shifting that resumes later continues the same bit sequence.
- R8: When `ir_code` differs from `OPCODE`, `tdo` is 0, `rd_en` is 0, and shift or capture pulses leave the scan position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous reset, active low |
| ir_code | input | IR_W | Current instruction code |
| capture_dr | input | 1 | Controller is in the capture state |
| shift_dr | input | 1 | Controller is in the shift state |
| rd_data | input | 8 | Page byte, valid the cycle after a strobe |
| rd_en | output | 1 | Read strobe to the page buffer |
| rd_addr | output | AW | Byte address of the read |
| tdo | output | 1 | Serial output |

## Verification
A wrong bit position or a wrong fetch state shows at the ports within one byte group. If the bit position is off by one, the strobe moves away from index 6 of its group, and the first mismatched `tdo` bit follows at most 8 cycles later. A stale or skipped address puts the wrong byte on `tdo` in the group that follows the fetch. A stuck end-of-page flag shows either as an extra strobe after the last byte or as zeros in place of page data. The bench drives a full scan, scans broken by pauses, mid-page recaptures and foreign instruction codes. It compares every cycle against a bit index kept in the bench.

// File: rtl/pgrd_pkg.sv
package pgrd_pkg;
  localparam int BYTE_W = 8;

  function automatic int page_bytes(input int bits);
    return bits / BYTE_W;
  endfunction

  function automatic int addr_width(input int nbytes);
    return (nbytes > 1) ? $clog2(nbytes) : 1;
  endfunction
endpackage

// File: rtl/pgrd_bitpos.sv
module pgrd_bitpos (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       advance,
  output logic       pre_slot,
  output logic       last_slot
);
  logic [2:0] pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pos_q <= 3'd0;
    else if (restart) pos_q <= 3'd0;
    else if (advance) pos_q <= pos_q + 3'd1;
  end

  assign pre_slot  = (pos_q == 3'd6);
  assign last_slot = (pos_q == 3'd7);
endmodule

// File: rtl/pgrd_fetch.sv
module pgrd_fetch #(
  parameter int NBYTES = 128,
  parameter int AW     = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          strobe_slot,
  input  logic          load_slot,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          take
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(NBYTES - 1);

  logic [AW-1:0] addr_q;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      done_q <= 1'b0;
    end else if (restart) begin
      addr_q <= '0;
      done_q <= 1'b0;
    end else if (take) begin
      if (addr_q == LAST_ADDR) done_q <= 1'b1;
      else                     addr_q <= addr_q + 1'b1;
    end
  end

  assign rd_en   = strobe_slot && !done_q;
  assign take    = load_slot && !done_q;
  assign rd_addr = addr_q;
endmodule

// File: rtl/pgrd_shifter.sv
module pgrd_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         advance,
  input  logic         boundary,
  input  logic         take,
  input  logic [W-1:0] din,
  output logic         lsb
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= '0;
    else if (clear)    sr_q <= '0;
    else if (advance) begin
      if (boundary)    sr_q <= take ? din : '0;
      else             sr_q <= {1'b0, sr_q[W-1:1]};
    end
  end

  assign lsb = sr_q[0];
endmodule

// File: rtl/page_read_dr.sv
module page_read_dr
  import pgrd_pkg::*;
#(
  parameter int          PAGE_BITS = 1024,
  parameter int          IR_W      = 4,
  parameter logic [3:0]  OPCODE    = 4'h7,
  parameter int          NBYTES    = page_bytes(PAGE_BITS),
  parameter int          AW        = addr_width(page_bytes(PAGE_BITS))
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic [IR_W-1:0]   ir_code,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  output logic              tdo
);
  logic selected, restart, advance;
  logic pre_slot, last_slot, take, lsb;

  assign selected = (ir_code == IR_W'(OPCODE));
  assign restart  = selected && capture_dr;
  assign advance  = selected && shift_dr && !capture_dr;

  pgrd_bitpos u_pos (
    .clk       (tck),
    .rst_n     (trst_n),
    .restart   (restart),
    .advance   (advance),
    .pre_slot  (pre_slot),
    .last_slot (last_slot)
  );

  pgrd_fetch #(.NBYTES(NBYTES), .AW(AW)) u_fetch (
    .clk         (tck),
    .rst_n       (trst_n),
    .restart     (restart),
    .strobe_slot (advance && pre_slot),
    .load_slot   (advance && last_slot),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .take        (take)
  );

  pgrd_shifter #(.W(BYTE_W)) u_sr (
    .clk      (tck),
    .rst_n    (trst_n),
    .clear    (restart),
    .advance  (advance),
    .boundary (last_slot),
    .take     (take),
    .din      (rd_data),
    .lsb      (lsb)
  );

  assign tdo = selected ? lsb : 1'b0;
endmodule

// File: rtl/pgrd_chk.sv
module pgrd_chk #(
  parameter int         IR_W   = 4,
  parameter logic [3:0] OPCODE = 4'h7,
  parameter int         AW     = 7
) (
  input logic            tck,
  input logic            trst_n,
  input logic [IR_W-1:0] ir_code,
  input logic            capture_dr,
  input logic            shift_dr,
  input logic            rd_en,
  input logic [AW-1:0]   rd_addr,
  input logic            tdo
);
  logic          sel;
  logic          have_prev;
  logic [AW-1:0] prev_addr;

  assign sel = (ir_code == IR_W'(OPCODE));

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      have_prev <= 1'b0;
      prev_addr <= '0;
    end else if (sel && capture_dr) begin
      have_prev <= 1'b0;
    end else if (rd_en) begin
      have_prev <= 1'b1;
      prev_addr <= rd_addr;
    end
  end

  // R8
  strobe_gate_chk: assert property (@(posedge tck) disable iff (!trst_n)
    rd_en |-> (sel && shift_dr && !capture_dr));

  // R4
  strobe_gap_chk: assert property (@(posedge tck) disable iff (!trst_n)
    rd_en |=> !rd_en);

  // R4
  strobe_step_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (rd_en && have_prev) |-> (rd_addr == prev_addr + 1'b1));

  // R5
  restart_addr_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (sel && capture_dr) |=> (rd_addr == '0));

  // R2
  restart_tdo_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (sel && capture_dr) |=> (tdo == 1'b0));

  // R8
  idle_tdo_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !sel |-> (tdo == 1'b0));
endmodule

bind page_read_dr pgrd_chk #(.IR_W(IR_W), .OPCODE(OPCODE), .AW(AW)) u_chk (
  .tck        (tck),
  .trst_n     (trst_n),
  .ir_code    (ir_code),
  .capture_dr (capture_dr),
  .shift_dr   (shift_dr),
  .rd_en      (rd_en),
  .rd_addr    (rd_addr),
  .tdo        (tdo)
);

// File: tb/sim_page_read_dr.sv
module sim_page_read_dr;
  localparam int PB = 1024;
  localparam int NB = PB / 8;
  localparam int AW = $clog2(NB);

  logic          tck = 1'b0;
  logic          trst_n = 1'b0;
  logic [3:0]    ir_code = 4'h0;
  logic          capture_dr = 1'b0;
  logic          shift_dr = 1'b0;
  logic [7:0]    rd_data = 8'h00;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic          tdo;

  int checks = 0;
  int errors = 0;
  int k = 0;
  int seed = 11;
  bit running = 1'b0;
  string phase = "";

  always #5 tck = ~tck;

  page_read_dr #(.PAGE_BITS(PB)) u0 (
    .tck(tck), .trst_n(trst_n), .ir_code(ir_code), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .rd_data(rd_data), .rd_en(rd_en), .rd_addr(rd_addr), .tdo(tdo)
  );

  function automatic logic [7:0] mem(input int i, input int s);
    return 8'((i * 37 + s * 5 + (i >> 3)) & 255);
  endfunction

  // page buffer: one-cycle read latency
  always @(posedge tck) if (rd_en) rd_data <= mem(int'(rd_addr), seed);

  // reference scan position
  always @(posedge tck) begin
    if (trst_n && ir_code == 4'h7) begin
      if (capture_dr)    k <= 0;
      else if (shift_dr) k <= k + 1;
    end
  end

  function automatic logic exp_tdo(input int kk);
    if (kk < 8 || kk >= PB + 8) return 1'b0;
    return mem((kk - 8) / 8, seed)[(kk - 8) % 8];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] k=%0d actual=%0d expected=%0d", req, phase, k, act, exp);
    end
  endtask

  always @(negedge tck) begin
    if (running && trst_n) begin
      logic sel, exp_en;
      string rq;
      sel    = (ir_code == 4'h7);
      exp_en = sel && shift_dr && !capture_dr && (k % 8 == 6) && (k / 8 < NB);
      rq = !sel ? "R8" : (k < 8) ? "R2" : (k < PB + 8) ? "R3" : "R6";
      check(rq, int'(tdo), sel ? int'(exp_tdo(k)) : 0);
      check((k / 8 < NB) ? "R4" : "R6", int'(rd_en), int'(exp_en));
      if (exp_en) check("R4", int'(rd_addr), k / 8);
    end
  end

  task automatic step(input logic c, input logic s, input logic [3:0] ir);
    @(posedge tck); #1;
    capture_dr = c; shift_dr = s; ir_code = ir;
  endtask

  initial begin
    #2;
    // R1: outputs quiet in reset
    check("R1", int'(tdo), 0);
    check("R1", int'(rd_en), 0);
    repeat (3) @(posedge tck);
    #1 trst_n = 1'b1;
    running = 1'b1;

    phase = "full scan";
    step(1, 0, 4'h7);
    repeat (PB + 8 + 24) step(0, 1, 4'h7);
    step(0, 0, 4'h7);

    phase = "R7 pauses";
    seed = 23;
    step(1, 0, 4'h7);
    for (int i = 0; i < 300; i++) step(0, (i % 13) != 5, 4'h7);
    repeat (4) step(0, 0, 4'h7);

    phase = "R8 foreign code";
    repeat (20) step(0, 1, 4'h3);
    step(1, 0, 4'h5);
    repeat (9) step(0, 1, 4'h2);
    repeat (40) step(0, 1, 4'h7);

    phase = "R5 recapture";
    step(1, 0, 4'h7);
    for (int i = 0; i < PB + 20; i++) step(0, (i % 29) != 3, 4'h7);
    step(0, 0, 4'h7);
    step(0, 0, 4'h7);
    running = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule